// File: doc/BRIEF.md
# Rotated Byte Immediate Encoder

This block takes a 32-bit constant and looks for a compact 12-bit form of it. The form is a 4-bit rotation index `r` and an 8-bit byte `v`. Such a pair stands for `v`, zero-extended to 32 bits and rotated right by `2*r` places. If a pair reproduces the constant, the block returns it. If no pair does, the block says the constant has no such form. Tools that emit immediates use it, for example an instruction selector or a constant-pool builder, to decide whether a constant can be placed inline.

The search is serial. A start pulse latches the constant. After that, one rotation index is tested per clock cycle, in ascending order from 0. The search ends at the first index that fits, or after index 15 if none fits. A one-cycle `done` pulse marks the end. The code word and the `encodable` flag then hold until the next accepted start.

The controller has three states:
- `S_IDLE`: waiting.
- `S_SCAN`: testing one index per cycle.
- `S_DONE`: the one-cycle completion marker.

It has five transitions:
- `S_IDLE` to `S_SCAN` on start.
- `S_SCAN` to `S_SCAN` when the current index misses and is not the last.
- `S_SCAN` to `S_DONE` on a hit.
- `S_SCAN` to `S_DONE` when the last index misses.
- `S_DONE` to `S_IDLE` unconditionally.

Top module: `rotimm_encoder`

## Requirements
- R1: When `encodable` is 1, `code_o[11:8]` holds `r` and `code_o[7:0]` holds `v`. The byte `v`, zero-extended to 32 bits and rotated right by `2*r`, equals the constant latched at start.
- R2: Where several indices fit, the smallest `r` is returned. The constant 0 returns `code_o = 0x000` with `encodable = 1`.
- R3: Each single set bit 0..31 is encodable. A byte of any value placed in any of the four byte lanes is encodable.
- R4: 0x0003FC00 returns `code_o = 0xBFF` (r = 11, v = 0xFF). 0xC0000034 returns `code_o = 0x1D3` (r = 1, v = 0xD3), where the byte's bits wrap across bit 31 and bit 0.
- R5: A constant with no fitting index returns `encodable = 0` and `code_o = 0x000`. Examples are 0x00000102 and 0xFF0000FF.
- R6: Counting the clock edge that samples start as edge 0, `done` is high after edge `r+1` for a hit at index `r`. For a constant with no fit, `done` is high after edge 16.
- R7: `done` is high for exactly one cycle. `busy` is high from edge 0 until the edge that raises `done`. `busy` and `done` are never high together.
- R8: A start pulse while `busy` or `done` is high is ignored. The result belongs to the constant accepted earlier.
- R9: An accepted start clears `encodable` and `code_o` to 0 while the search runs. After `done`, both outputs hold until the next accepted start.
- R10: During reset, `busy`, `done`, `encodable` and `code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a search; accepted only in `S_IDLE` |
| const_i | input | 32 | Constant to encode, sampled with an accepted start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| encodable_o | output | 1 | A fitting rotation index was found |
| code_o | output | 12 | Rotation index in bits 11:8, byte in bits 7:0 |

## Verification
Two events can meet in one cycle:
- A hit on the current index, which ends the scan.
- Reaching index 15, which also ends the scan and declares a miss.

A constant whose only fit is at index 15 provokes both at once. Rotated-byte constants for every index cover this case, and the bench checks that such a constant reports a hit at r = 15 with latency 16 rather than a miss. A second overlap is a new start arriving in the same cycle as an active search or the `done` pulse. The bench judges that case by the returned code word: it must still belong to the first constant.

// File: rtl/imm_enc_pkg.sv
package imm_enc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } enc_state_t;

endpackage

// File: rtl/imm_rot_probe.sv
// Combinational test of one rotation index: rotates the word left by
// STEP*rot and reports whether everything above the low byte is zero.
module imm_rot_probe #(
    parameter int WORD_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [ROT_W-1:0]  rot_i,
    output logic              fits_o,
    output logic [VAL_W-1:0]  value_o
);
    localparam int N_ROT = 1 << ROT_W;
    localparam int STEP  = WORD_W / N_ROT;
    localparam int IDX_W = $clog2(WORD_W);

    logic [IDX_W-1:0]  amt;
    logic [WORD_W-1:0] rotated;

    always_comb begin
        amt     = IDX_W'(STEP * int'(rot_i));
        rotated = '0;
        for (int i = 0; i < WORD_W; i++) begin
            rotated[IDX_W'(i) + amt] = word_i[i];
        end
    end

    assign fits_o  = ~|rotated[WORD_W-1:VAL_W];
    assign value_o = rotated[VAL_W-1:0];

endmodule

// File: rtl/imm_rot_counter.sv
// Rotation index counter for the serial scan.
module imm_rot_counter #(
    parameter int ROT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [ROT_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [ROT_W-1:0] IDX_MAX = {ROT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clr_i) begin
            idx_o <= '0;
        end else if (adv_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    assign last_o = (idx_o == IDX_MAX);

    // R6: each advance moves exactly one index forward
    a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (idx_o == $past(idx_o) + 1'b1));

    // R6: a new search begins at index zero
    a_r6_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (idx_o == '0));

endmodule

// File: rtl/imm_enc_result.sv
// Holds the returned code word and flag between searches.
module imm_enc_result #(
    parameter int WORD_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    load_i,
    input  logic [ROT_W+VAL_W-1:0]  code_i,
    input  logic [WORD_W-1:0]       ref_word_i,
    output logic [ROT_W+VAL_W-1:0]  code_o,
    output logic                    ok_o
);
    localparam int N_ROT = 1 << ROT_W;
    localparam int STEP  = WORD_W / N_ROT;
    localparam int IDX_W = $clog2(WORD_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            ok_o   <= 1'b0;
        end else if (clr_i) begin
            code_o <= '0;
            ok_o   <= 1'b0;
        end else if (load_i) begin
            code_o <= code_i;
            ok_o   <= 1'b1;
        end
    end

    // Expansion of the held code word, used only by the check below.
    logic [IDX_W-1:0]  exp_amt;
    logic [WORD_W-1:0] expanded;

    always_comb begin
        exp_amt  = IDX_W'(STEP * int'(code_o[ROT_W+VAL_W-1:VAL_W]));
        expanded = '0;
        for (int i = 0; i < VAL_W; i++) begin
            expanded[IDX_W'(i) - exp_amt] = code_o[i];
        end
    end

    // R1: a reported code expands back to the latched constant
    a_r1_code_expands: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (expanded == ref_word_i));

    // R5: a cleared result carries a zero code word
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_o |-> (code_o == '0));

    // R9: with no clear or load the result holds
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_i) |=> ($stable(code_o) && $stable(ok_o)));

endmodule

// File: rtl/rotimm_encoder.sv
module rotimm_encoder
    import imm_enc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [WORD_W-1:0]      const_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   encodable_o,
    output logic [ROT_W+VAL_W-1:0] code_o
);
    localparam int CODE_W = ROT_W + VAL_W;

    enc_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [ROT_W-1:0]  idx;
    logic              idx_last;
    logic              fits;
    logic [VAL_W-1:0]  value;
    logic              accept;
    logic              scan_hit;
    logic              scan_miss_end;
    logic              cnt_adv;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_SCAN;
            S_SCAN: if (fits || idx_last) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        busy_o        = 1'b0;
        done_o        = 1'b0;
        accept        = 1'b0;
        scan_hit      = 1'b0;
        scan_miss_end = 1'b0;
        cnt_adv       = 1'b0;
        unique case (state_q)
            S_IDLE: accept = start_i;
            S_SCAN: begin
                busy_o        = 1'b1;
                scan_hit      = fits;
                scan_miss_end = !fits && idx_last;
                cnt_adv       = !fits && !idx_last;
            end
            S_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    // Constant latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= const_i;
        end
    end

    imm_rot_counter #(
        .ROT_W (ROT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .adv_i  (cnt_adv),
        .idx_o  (idx),
        .last_o (idx_last)
    );

    imm_rot_probe #(
        .WORD_W (WORD_W),
        .VAL_W  (VAL_W),
        .ROT_W  (ROT_W)
    ) u_probe (
        .word_i  (word_q),
        .rot_i   (idx),
        .fits_o  (fits),
        .value_o (value)
    );

    logic [CODE_W-1:0] code_next;
    assign code_next = {idx, value};

    imm_enc_result #(
        .WORD_W (WORD_W),
        .VAL_W  (VAL_W),
        .ROT_W  (ROT_W)
    ) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept || scan_miss_end),
        .load_i     (scan_hit),
        .code_i     (code_next),
        .ref_word_i (word_q),
        .code_o     (code_o),
        .ok_o       (encodable_o)
    );

    // R7: busy and done never overlap
    a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the latched constant is untouched by starts during a search
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (busy_o || done_o)) |=> $stable(word_q));

    // R6: the last index always ends the search
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_last) |=> done_o);

    // R9: an accepted start clears the result and raises busy
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i) |=> (busy_o && !encodable_o && code_o == '0));

endmodule

// File: tb/test_rotimm_encoder.sv
`timescale 1ns/1ps
module test_rotimm_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] const_i = '0;
    logic        busy_o, done_o, encodable_o;
    logic [11:0] code_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rotimm_encoder i_rotimm_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .const_i     (const_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .encodable_o (encodable_o),
        .code_o      (code_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rotl(input logic [31:0] x, input int amt);
        return (x << amt) | (x >> (32 - amt));
    endfunction

    function automatic logic [31:0] rotr(input logic [31:0] x, input int amt);
        return (x >> amt) | (x << (32 - amt));
    endfunction

    // Returns {ok, r, v} for the smallest fitting index
    function automatic logic [12:0] model(input logic [31:0] x);
        for (int r = 0; r < 16; r++) begin
            logic [31:0] y;
            y = rotl(x, 2 * r);
            if (y[31:8] == 24'd0) return {1'b1, 4'(r), y[7:0]};
        end
        return 13'd0;
    endfunction

    // Starts one search, waits for done and checks everything about it
    task automatic run(input logic [31:0] x, input string tag);
        logic [12:0] m;
        int lat;
        int exp_lat;
        logic [11:0] held;
        logic held_ok;
        m = model(x);
        @(negedge clk);
        const_i = x;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !encodable_o && code_o == 12'd0, "R9 clear at start",
            {19'd0, busy_o, encodable_o, code_o}, 32'h1000);
        lat = 0;
        while (!done_o && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        exp_lat = m[12] ? int'(m[11:8]) + 1 : 16;
        chk(lat == exp_lat, "R6 latency", lat, exp_lat);
        chk(!busy_o, "R7 busy low with done", {31'd0, busy_o}, 32'd0);
        chk(encodable_o == m[12] && code_o == m[11:0],
            {tag, " code/flag (R2 smallest r)"},
            {19'd0, encodable_o, code_o}, {19'd0, m});
        if (encodable_o) begin
            chk(rotr({24'd0, code_o[7:0]}, 2 * int'(code_o[11:8])) == x,
                "R1 expansion", rotr({24'd0, code_o[7:0]}, 2 * int'(code_o[11:8])), x);
        end
        held = code_o;
        held_ok = encodable_o;
        @(negedge clk);
        chk(!done_o && !busy_o, "R7 done one cycle", {30'd0, done_o, busy_o}, 32'd0);
        chk(code_o == held && encodable_o == held_ok, "R9 hold after done",
            {19'd0, encodable_o, code_o}, {19'd0, held_ok, held});
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [11:0] held;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !encodable_o && code_o == 12'd0, "R10 reset",
            {17'd0, busy_o, done_o, encodable_o, code_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 named examples and R5 misses
        run(32'h0003FC00, "R4");
        chk(code_o == 12'hBFF, "R4 0x3FC00", {20'd0, code_o}, 32'hBFF);
        run(32'hC0000034, "R4");
        chk(code_o == 12'h1D3, "R4 wrap 0xC0000034", {20'd0, code_o}, 32'h1D3);
        run(32'h00000102, "R5");
        chk(!encodable_o && code_o == 12'd0, "R5 0x102",
            {19'd0, encodable_o, code_o}, 32'd0);
        run(32'hFF0000FF, "R5");
        chk(!encodable_o && code_o == 12'd0, "R5 0xFF0000FF",
            {19'd0, encodable_o, code_o}, 32'd0);

        // R2 zero constant
        run(32'd0, "R2");
        chk(encodable_o && code_o == 12'd0, "R2 zero",
            {19'd0, encodable_o, code_o}, 32'h1000);

        // R3 single bits and byte lanes
        for (int b = 0; b < 32; b++) begin
            run(32'd1 << b, "R3 bit");
            chk(encodable_o, "R3 power of two", {31'd0, encodable_o}, 32'd1);
        end
        for (int lane = 0; lane < 4; lane++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] bv;
                bv = (k == 0) ? 8'hFF : (k == 1) ? 8'h81 : (k == 2) ? 8'h5A : 8'h01;
                run({24'd0, bv} << (8 * lane), "R3 lane");
                chk(encodable_o, "R3 byte lane", {31'd0, encodable_o}, 32'd1);
            end
        end

        // R1/R2: every byte at every index, including hit on the last index
        for (int r = 0; r < 16; r++) begin
            for (int v = 0; v < 256; v++) begin
                run(rotr(32'(v), 2 * r), "R1 sweep");
            end
        end

        // R5: pseudo-random constants, mostly without a fit
        lfsr = 32'hACE1_1357;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr, "R5 random");
        end

        // R8: start while busy, then start during done
        @(negedge clk);
        const_i = 32'h0003FC00;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        const_i = 32'h00000001;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        start_i = 1'b0;
        while (!done_o) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(encodable_o && code_o == 12'hBFF, "R8 start while busy",
            {19'd0, encodable_o, code_o}, 32'h1BFF);
        held = code_o;
        const_i = 32'h00000102;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && code_o == held && encodable_o, "R8 start during done",
            {19'd0, busy_o, code_o}, {20'd0, held});
        repeat (2) @(negedge clk);
        chk(!busy_o && code_o == held && encodable_o, "R9 hold while idle",
            {19'd0, busy_o, code_o}, {20'd0, held});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule